// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels owns the transfer engine next. A channel asks for service either through its hardware request line or through a software request flag set by the processor. Each channel has a mask bit that hides its requests. A global disable bit stops any new grant. The winner is chosen by fixed or rotating priority. It holds the grant until the engine reports that the service is finished, and the done report can also say that the channel reached terminal count.

The processor reaches the block through a small register port. The port uses an active-low chip-select, active-low read and write strobes, and a 4-bit register address. With address bit 3 high, the processor can reach four registers:
- address 4'b1000: write control, read status.
- address 4'b1001: software request flags.
- address 4'b1010: mask bits.
- address 4'b1011: control readback.

Addresses with bit 3 low belong to the address and count registers of the transfer engine, which live outside this block.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset no grant is active, all four mask bits read 1 at address 4'b1010, and the control readback and status both read 0.
- R2: A channel whose mask bit (bit n of the mask register) is 1 is never granted, whatever its requests.
- R3: While control bit 2 is 1, no new grant is issued. When it returns to 0, pending requests are granted again.
- R4: With control bit 4 at 0 (fixed priority), channel 0 wins over all others and channel 3 loses to all others.
- R5: With control bit 4 at 1 (rotating priority), the channel just serviced becomes the lowest priority and the channel after it, in the order 0,1,2,3,0, becomes the highest.
- R6: Once granted, the channel number and the grant stay unchanged until `svc_done_i` is seen, even if a higher-priority request arrives.
- R7: A 1 in bit n of the software request register (address 4'b1001) requests channel n just as the hardware line does. The flag is cleared when that channel's service ends with `svc_tc_i` high. It stays set when the service ends with `svc_tc_i` low.
- R8: Status bits 7:4 show the live request of channels 3..0 (hardware line OR software flag), regardless of mask or disable.
- R9: Status bit n (n = 0..3) is set when channel n's service ends with `svc_tc_i` high. It stays set until the status register is read, and the read clears it.
- R10: With chip-select high, or with address bit 3 low, writes change nothing and the read data is 0.
- R11: In the cycle after a done report, the grant is low, so two grants are always separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_req_i | input | 4 | Hardware request lines, active high, one per channel |
| reg_cs_n | input | 1 | Register port chip-select, active low |
| reg_rd_n | input | 1 | Register read strobe, active low |
| reg_wr_n | input | 1 | Register write strobe, active low |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, 0 when not reading a register of this block |
| svc_done_i | input | 1 | The granted channel's service is finished |
| svc_tc_i | input | 1 | Qualifies `svc_done_i`: the channel reached terminal count |
| grant_valid_o | output | 1 | A channel is granted |
| grant_ch_o | output | 2 | Number of the granted channel |

## Verification
The hardest case to reach from the ports is the full walk of the rotating pointer. Every channel must win exactly once while all four keep requesting, and the starting point depends on which channel was serviced last, in whatever mode. The stimulus first leaves channel 0 as the last one served, under fixed priority. It then switches to rotating mode with all four lines held high, and expects the grants in the order 1, 2, 3, 0. The sticky terminal-count bits are also checked for both kinds of done report: a service that ends without terminal count must leave both the status bit and the software flag untouched.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  // register selects below address bit 3
  localparam logic [2:0] SEL_CTRL_STAT = 3'b000;
  localparam logic [2:0] SEL_SWREQ     = 3'b001;
  localparam logic [2:0] SEL_MASK      = 3'b010;
  localparam logic [2:0] SEL_CTRL_RB   = 3'b011;

  // control register bit positions
  localparam int CTRL_DIS_BIT = 2;
  localparam int CTRL_ROT_BIT = 4;

  typedef struct packed {
    logic rot;
    logic dis;
  } ctrl_t;
endpackage

// File: rtl/dmarb_prio.sv
module dmarb_prio #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req,
  input  logic [CH_W-1:0] base,
  output logic            found,
  output logic [CH_W-1:0] pick
);
  // scan from the highest offset down so the lowest offset from base wins
  always_comb begin
    logic [CH_W-1:0] idx;
    found = 1'b0;
    pick  = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      idx = base + CH_W'(i);
      if (req[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end
endmodule

// File: rtl/dmarb_grant.sv
module dmarb_grant #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            found,
  input  logic [CH_W-1:0] pick,
  input  logic            svc_done,
  input  logic            svc_tc,
  output logic            gv_q,
  output logic [CH_W-1:0] ch_q,
  output logic [CH_W-1:0] base_q,
  output logic [N_CH-1:0] tc_hit
);
  logic            gv_d;
  logic [CH_W-1:0] ch_d;
  logic [CH_W-1:0] base_d;
  logic            upd_en;
  logic            finish;

  assign finish = gv_q & svc_done;
  assign upd_en = finish | (~gv_q & found);

  always_comb begin
    gv_d   = gv_q;
    ch_d   = ch_q;
    base_d = base_q;
    if (gv_q) begin
      if (svc_done) begin
        gv_d   = 1'b0;
        base_d = ch_q + CH_W'(1);
      end
    end else if (found) begin
      gv_d = 1'b1;
      ch_d = pick;
    end
  end

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_tc
      assign tc_hit[g] = finish & svc_tc & (ch_q == CH_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q   <= 1'b0;
      ch_q   <= '0;
      base_q <= '0;
    end else if (upd_en) begin
      gv_q   <= gv_d;
      ch_q   <= ch_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/dmarb_regs.sv
module dmarb_regs
  import dmarb_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_CH-1:0]   hw_req,
  input  logic [N_CH-1:0]   tc_hit,
  output logic [DATA_W-1:0] rdata,
  output logic [N_CH-1:0]   mask_q,
  output logic [N_CH-1:0]   swreq_q,
  output ctrl_t             ctrl_q
);
  logic              own_sel;
  logic              wr_en;
  logic              rd_en;
  logic              stat_rd;
  logic              stat_rd_q;
  logic              stat_clr;
  logic [N_CH-1:0]   live_req;
  logic [N_CH-1:0]   tc_q;
  logic [N_CH-1:0]   tc_d;
  logic [N_CH-1:0]   mask_d;
  logic [N_CH-1:0]   swreq_d;
  ctrl_t             ctrl_d;

  assign own_sel  = ~cs_n & addr[3];
  assign wr_en    = own_sel & ~wr_n;
  assign rd_en    = own_sel & ~rd_n;
  assign stat_rd  = rd_en & (addr[2:0] == SEL_CTRL_STAT);
  assign stat_clr = stat_rd & ~stat_rd_q;
  assign live_req = hw_req | swreq_q;

  always_comb begin
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    swreq_d = swreq_q & ~tc_hit;
    if (wr_en) begin
      case (addr[2:0])
        SEL_CTRL_STAT: begin
          ctrl_d.dis = wdata[CTRL_DIS_BIT];
          ctrl_d.rot = wdata[CTRL_ROT_BIT];
        end
        SEL_SWREQ: swreq_d = wdata[N_CH-1:0];
        SEL_MASK:  mask_d  = wdata[N_CH-1:0];
        default: ;
      endcase
    end
  end

  // sticky terminal-count bits: a new hit wins over a clearing read
  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_tcbit
      assign tc_d[g] = tc_hit[g] | (tc_q[g] & ~stat_clr);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr[2:0])
        SEL_CTRL_STAT: begin
          rdata[N_CH-1:0]    = tc_q;
          rdata[N_CH+:N_CH]  = live_req;
        end
        SEL_SWREQ: rdata[N_CH-1:0] = swreq_q;
        SEL_MASK:  rdata[N_CH-1:0] = mask_q;
        SEL_CTRL_RB: begin
          rdata[CTRL_DIS_BIT] = ctrl_q.dis;
          rdata[CTRL_ROT_BIT] = ctrl_q.rot;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mask_q    <= '1;
      swreq_q   <= '0;
      tc_q      <= '0;
      stat_rd_q <= 1'b0;
    end else begin
      if (wr_en) begin
        ctrl_q <= ctrl_d;
        mask_q <= mask_d;
      end
      swreq_q   <= swreq_d;
      tc_q      <= tc_d;
      stat_rd_q <= stat_rd;
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dmarb_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 8,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hw_req_i,
  input  logic              reg_cs_n,
  input  logic              reg_rd_n,
  input  logic              reg_wr_n,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              svc_done_i,
  input  logic              svc_tc_i,
  output logic              grant_valid_o,
  output logic [CH_W-1:0]   grant_ch_o
);
  logic            rst_s1;
  logic            rst_sync_n;
  logic [N_CH-1:0] mask_q;
  logic [N_CH-1:0] swreq_q;
  ctrl_t           ctrl_q;
  logic            ctrl_dis;
  logic            ctrl_rot;
  logic [N_CH-1:0] eff_req;
  logic [N_CH-1:0] tc_hit;
  logic [CH_W-1:0] base_q;
  logic [CH_W-1:0] prio_base;
  logic            found;
  logic [CH_W-1:0] pick;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  dmarb_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cs_n    (reg_cs_n),
    .rd_n    (reg_rd_n),
    .wr_n    (reg_wr_n),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .hw_req  (hw_req_i),
    .tc_hit  (tc_hit),
    .rdata   (reg_rdata),
    .mask_q  (mask_q),
    .swreq_q (swreq_q),
    .ctrl_q  (ctrl_q)
  );

  assign ctrl_dis  = ctrl_q.dis;
  assign ctrl_rot  = ctrl_q.rot;
  assign eff_req   = ctrl_dis ? '0 : ((hw_req_i | swreq_q) & ~mask_q);
  assign prio_base = ctrl_rot ? base_q : '0;

  dmarb_prio #(.N_CH(N_CH)) u_prio (
    .req   (eff_req),
    .base  (prio_base),
    .found (found),
    .pick  (pick)
  );

  dmarb_grant #(.N_CH(N_CH)) u_grant (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .found    (found),
    .pick     (pick),
    .svc_done (svc_done_i),
    .svc_tc   (svc_tc_i),
    .gv_q     (grant_valid_o),
    .ch_q     (grant_ch_o),
    .base_q   (base_q),
    .tc_hit   (tc_hit)
  );
endmodule

// File: rtl/dmarb_checker.sv
module dmarb_checker #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gv,
  input logic [CH_W-1:0] ch,
  input logic            svc_done,
  input logic            dis,
  input logic            rot,
  input logic [N_CH-1:0] eff_req
);
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    gv && !svc_done |=> gv && $stable(ch)); // R6

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    gv && svc_done |=> !gv); // R11

  AST_DISABLED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !gv && dis |=> !gv); // R3

  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !gv && (eff_req == '0) |=> !gv); // R2

  AST_FIXED_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !gv && !rot && eff_req[0] |=> gv && (ch == '0)); // R4
endmodule

bind dma_chan_arbiter dmarb_checker #(.N_CH(N_CH)) u_dmarb_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .gv       (grant_valid_o),
  .ch       (grant_ch_o),
  .svc_done (svc_done_i),
  .dis      (ctrl_dis),
  .rot      (ctrl_rot),
  .eff_req  (eff_req)
);

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
  localparam time CLK_P = 5ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hw_req = '0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       svc_done = 1'b0, svc_tc = 1'b0;
  logic       gv;
  logic [1:0] gch;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  logic prev_gv = 1'b0;
  logic [7:0] rv;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_arbiter i_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req),
    .reg_cs_n(cs_n), .reg_rd_n(rd_n), .reg_wr_n(wr_n),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .svc_done_i(svc_done), .svc_tc_i(svc_tc),
    .grant_valid_o(gv), .grant_ch_o(gch)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every new grant pops one expected channel
  always @(negedge clk) begin
    if (rst_n && gv && !prev_gv) begin
      if (exp_q.size() == 0) check("R4/R5 unexpected grant", int'(gch), -1);
      else check("R4/R5 grant order", int'(gch), exp_q.pop_front());
    end
    prev_gv = gv;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic cs = 1'b0);
    @(negedge clk);
    cs_n = cs; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, input logic cs = 1'b0);
    @(negedge clk);
    cs_n = cs; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wait_grant();
    int t = 0;
    while (!gv && t < 100) begin @(negedge clk); t++; end
    if (!gv) check("grant timeout", 0, 1);
  endtask

  task automatic serve(input logic tc, input logic [3:0] drop);
    wait_grant();
    repeat (2) @(negedge clk);
    svc_done = 1'b1; svc_tc = tc;
    @(negedge clk);
    svc_done = 1'b0; svc_tc = 1'b0;
    hw_req = hw_req & ~drop;
    check("R11 idle after done", int'(gv), 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 grant idle", int'(gv), 0);
    rd(4'hA, rv); check("R1 mask all set", rv, 8'h0F);
    rd(4'hB, rv); check("R1 control zero", rv, 8'h00);
    rd(4'h8, rv); check("R1 status zero", rv, 8'h00);

    // R10 deselected or low-half access
    wr(4'hA, 8'h00, 1'b1);
    rd(4'hA, rv); check("R10 write with cs high ignored", rv, 8'h0F);
    wr(4'h2, 8'h00);
    rd(4'hA, rv); check("R10 write with a3 low ignored", rv, 8'h0F);
    rd(4'h2, rv); check("R10 read with a3 low is 0", rv, 8'h00);
    rd(4'hA, rv, 1'b1); check("R10 read with cs high is 0", rv, 8'h00);

    // R4 fixed priority, R6 hold
    wr(4'hA, 8'h00);
    exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(3);
    hw_req = 4'b1010;
    wait_grant();
    hw_req[0] = 1'b1;
    @(negedge clk);
    check("R6 grant held ch", int'(gch), 1);
    check("R6 grant held valid", int'(gv), 1);
    serve(1'b1, 4'b0010);
    serve(1'b1, 4'b0001);
    serve(1'b1, 4'b1000);

    // R9 sticky terminal count, cleared on read
    rd(4'h8, rv); check("R9 tc bits 0,1,3", rv, 8'h0B);
    rd(4'h8, rv); check("R9 cleared by read", rv, 8'h00);

    // R2 mask, R8 live request in status
    wr(4'hA, 8'h04);
    hw_req = 4'b0100;
    repeat (5) @(negedge clk);
    check("R2 masked not granted", int'(gv), 0);
    rd(4'h8, rv); check("R8 live request shown", rv, 8'h40);
    exp_q.push_back(2);
    wr(4'hA, 8'h00);
    serve(1'b0, 4'b0100);
    rd(4'h8, rv); check("R9 no tc without tc flag", rv, 8'h00);

    // R3 global disable
    wr(4'h8, 8'h04);
    rd(4'hB, rv); check("R3 control readback", rv, 8'h04);
    hw_req = 4'b0001;
    repeat (5) @(negedge clk);
    check("R3 disabled no grant", int'(gv), 0);
    exp_q.push_back(0);
    wr(4'h8, 8'h00);
    serve(1'b0, 4'b0001);

    // R5 rotating priority, last served was channel 0
    wr(4'h8, 8'h10);
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(0);
    hw_req = 4'b1111;
    serve(1'b0, 4'b0000);
    serve(1'b0, 4'b0000);
    serve(1'b0, 4'b0000);
    serve(1'b0, 4'b1111);

    // R7 software request flags
    wr(4'h8, 8'h00);
    exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(3);
    wr(4'h9, 8'h04);
    rd(4'h9, rv); check("R7 flag set", rv, 8'h04);
    serve(1'b1, 4'b0000);
    rd(4'h9, rv); check("R7 flag cleared on tc", rv, 8'h00);
    wr(4'h9, 8'h08);
    serve(1'b0, 4'b0000);
    rd(4'h9, rv); check("R7 flag kept without tc", rv, 8'h08);
    serve(1'b1, 4'b0000);
    rd(4'h9, rv); check("R7 flag cleared at end", rv, 8'h00);
    rd(4'h8, rv); check("R9 tc bits 2,3", rv, 8'h0C);

    repeat (5) @(negedge clk);
    check("R4/R5 scoreboard drained", exp_q.size(), 0);
    check("R11 idle at end", int'(gv), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule